// File: doc/BRIEF.md
# Split-Width Dword Register Bridge

This block is a slave on an asynchronous SRAM-style bus. It exposes a bank of 128 dword registers to a host that drives an active-low chip select, active-low read and write strobes, a 7-bit word address and a data bus. All bus inputs are sampled in the local clock domain. On its inner side the block drives a simple register-file port. That port has a one-cycle write strobe, a one-cycle read strobe, a word address and a combinational read-data return.

A static strap pin selects the bus width. In full-width mode, one bus cycle moves one whole dword. In split mode, the host moves each dword as two 16-bit cycles to the same word address, lower half first.

- On a split write, the lower half is parked in a staging register. The inner write of all 32 bits is issued only when the matching upper half arrives.
- On a split read, the lower-half cycle takes a snapshot of the whole register. The upper-half cycle returns the top of that same snapshot, even if the register has changed in between.

A pending half is discarded, and the next cycle is treated as a new lower half, in three cases: after a reset, after a cycle to a different address, and after a cycle in the other direction.

Top module: `dword_reg_bridge`

## Requirements
- R1: After reset, no inner read or write strobe is issued, the bus data output enable is low, and the pairing state expects a lower half.
- R2: With the width pin high (full width), each bus write cycle issues exactly one inner write carrying all 32 data bits to the addressed word.
- R3: With the width pin low (split), a write cycle that is a lower half issues no inner write and stages data bits 15:0. The following upper-half write to the same address issues one inner write of {upper bits 15:0, staged bits}.
- R4: With the width pin high, a read cycle returns the addressed 32-bit register on the data bus while the read strobe is held.
- R5: With the width pin low, a lower-half read returns register bits 15:0 in data bits 15:0, with bits 31:16 zero. The following upper-half read to the same address returns bits 31:16 of the snapshot taken at the lower half, and issues no inner read.
- R6: In split mode, a cycle whose address differs from the pending lower half is treated as a new lower half. The earlier pending half is dropped and causes no inner write.
- R7: The data output enable is high only during a read cycle, and is low during write cycles and idle.
- R8: A reset between the two halves discards the pending lower half. The next cycle is a lower half and issues no inner write.
- R9: In split mode, a cycle in the other direction from the pending lower half starts a new pair. At most one inner action is decoded per clock.
- R10: All 7 address bits are decoded. Word 127 (byte offset 1FCh) and word 0 are reached independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busCsN | input | 1 | Bus chip select, active low |
| busRdN | input | 1 | Bus read strobe, active low |
| busWrN | input | 1 | Bus write strobe, active low |
| busWideN | input | 1 | Width strap: low = 16-bit split, high = 32-bit |
| busAddr | input | 7 | Dword address (byte address bits 8:2) |
| busDataIn | input | 32 | Bus write data |
| busDataOut | output | 32 | Bus read data |
| busDataOe | output | 1 | Drive enable for busDataOut |
| regAddr | output | 7 | Inner register word address |
| regWrEn | output | 1 | Inner write strobe, one cycle |
| regWrData | output | 32 | Inner write data, little-endian |
| regRdEn | output | 1 | Inner read strobe, one cycle |
| regRdData | input | 32 | Inner read data, valid in the regRdEn cycle |

## Verification
The bench builds the block with its default parameters. These are a 7-bit address, a 32-bit data path and a two-stage input synchronizer. With these values both ends of the address range are reachable, and the full split-versus-wide behaviour is covered.

Bus cycles are held for six clocks so that the three-register path from strobe to output is visible. This also lets the bench change a register between the two halves of a split read, which shows that the upper half comes from the snapshot and not from the live register. Write pairing is disturbed three ways: an address change, a direction change and a reset between halves.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef struct packed {
    logic capAddr;
    logic capData;
    logic wide;
    logic rdLow;
    logic rdHigh;
    logic rdFull;
    logic wrLow;
    logic wrHigh;
    logic wrFull;
    logic oe;
    logic outHi;
  } bridgeStrobe_t;
endpackage

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCsN,
  input  logic              busRdN,
  input  logic              busWrN,
  input  logic              busWideN,
  input  logic [ADDR_W-1:0] addrNow,
  output bridgeStrobe_t     st
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] rdPipe, wrPipe;
  logic rdPrev, wrPrev, wideQ;
  logic hiHalf, pairWrite, outHi;
  logic [ADDR_W-1:0] pairAddr;
  logic rdStart, wrEnd, sameAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPipe <= '0;
      wrPipe <= '0;
      rdPrev <= 1'b0;
      wrPrev <= 1'b0;
      wideQ  <= 1'b1;
    end else begin
      rdPipe <= {rdPipe[SYNC_STAGES-2:0], ~busCsN & ~busRdN};
      wrPipe <= {wrPipe[SYNC_STAGES-2:0], ~busCsN & ~busWrN};
      rdPrev <= rdPipe[LAST];
      wrPrev <= wrPipe[LAST];
      wideQ  <= busWideN;
    end
  end

  assign rdStart  = rdPipe[LAST] & ~rdPrev;
  assign wrEnd    = ~wrPipe[LAST] & wrPrev;
  assign sameAddr = hiHalf && (pairAddr == addrNow);

  always_comb begin
    st         = '0;
    st.capAddr = rdPipe[0] | wrPipe[0];
    st.capData = wrPipe[0];
    st.wide    = wideQ;
    st.rdFull  = rdStart & wideQ;
    st.rdHigh  = rdStart & ~wideQ & sameAddr & ~pairWrite;
    st.rdLow   = rdStart & ~wideQ & ~st.rdHigh;
    st.wrFull  = wrEnd & wideQ;
    st.wrHigh  = wrEnd & ~wideQ & sameAddr & pairWrite;
    st.wrLow   = wrEnd & ~wideQ & ~st.wrHigh;
    st.oe      = rdPipe[LAST] & rdPrev;
    st.outHi   = outHi;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiHalf    <= 1'b0;
      pairWrite <= 1'b0;
      pairAddr  <= '0;
      outHi     <= 1'b0;
    end else begin
      if (st.rdLow || st.wrLow) begin
        hiHalf    <= 1'b1;
        pairAddr  <= addrNow;
        pairWrite <= st.wrLow;
      end else if (st.rdHigh || st.wrHigh || st.rdFull || st.wrFull) begin
        hiHalf <= 1'b0;
      end
      if (rdStart) outHi <= st.rdHigh;
    end
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.rdLow, st.rdHigh, st.rdFull, st.wrLow, st.wrHigh, st.wrFull})); // R9
  AST_LOW_ARMS_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdLow || st.wrLow) |=> hiHalf); // R3
  AST_FULL_NO_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdFull || st.wrFull) |=> !hiHalf); // R2
  AST_OE_NOT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    st.oe |-> !wrPipe[LAST]); // R7
endmodule

// File: rtl/bridge_dpath.sv
module bridge_dpath
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bridgeStrobe_t     st,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] busDataOut,
  output logic [ADDR_W-1:0] addrLatch,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] dataLatch, snap;
  logic [HALF_W-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLatch <= '0;
      dataLatch <= '0;
      stage     <= '0;
      snap      <= '0;
    end else begin
      if (st.capAddr) addrLatch <= busAddr;
      if (st.capData) dataLatch <= busDataIn;
      if (st.wrLow)   stage     <= dataLatch[HALF_W-1:0];
      if (st.rdLow || st.rdFull) snap <= regRdData;
    end
  end

  assign regWrData = st.wide ? dataLatch : {dataLatch[HALF_W-1:0], stage};

  always_comb begin
    if (!st.oe)        busDataOut = '0;
    else if (st.wide)  busDataOut = snap;
    else if (st.outHi) busDataOut = {{HALF_W{1'b0}}, snap[DATA_W-1:HALF_W]};
    else               busDataOut = {{HALF_W{1'b0}}, snap[HALF_W-1:0]};
  end

  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(st.rdLow || st.rdFull) |=> $stable(snap)); // R5
  AST_STAGE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !st.wrLow |=> $stable(stage)); // R3
endmodule

// File: rtl/dword_reg_bridge.sv
module dword_reg_bridge
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCsN,
  input  logic              busRdN,
  input  logic              busWrN,
  input  logic              busWideN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData,
  output logic              regRdEn,
  input  logic [DATA_W-1:0] regRdData
);
  bridgeStrobe_t st;
  logic [ADDR_W-1:0] addrLatch;

  bridge_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .busCsN(busCsN), .busRdN(busRdN), .busWrN(busWrN),
    .busWideN(busWideN), .addrNow(addrLatch), .st(st)
  );

  bridge_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpath (
    .clk(clk), .rstN(rstN), .st(st), .busAddr(busAddr), .busDataIn(busDataIn),
    .busDataOut(busDataOut), .addrLatch(addrLatch), .regWrData(regWrData),
    .regRdData(regRdData)
  );

  assign regAddr   = addrLatch;
  assign regWrEn   = st.wrHigh | st.wrFull;
  assign regRdEn   = st.rdLow | st.rdFull;
  assign busDataOe = st.oe;

  AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn)); // R9
endmodule

// File: tb/test_dword_reg_bridge.sv
module test_dword_reg_bridge;
  logic clk = 1'b0, rstN = 1'b0;
  logic busCsN = 1'b1, busRdN = 1'b1, busWrN = 1'b1, busWideN = 1'b1;
  logic [6:0] busAddr = '0;
  logic [31:0] busDataIn = '0;
  logic [31:0] busDataOut, regWrData, regRdData;
  logic busDataOe, regWrEn, regRdEn;
  logic [6:0] regAddr;

  logic [31:0] mem [128];
  int checks = 0, errors = 0, wrCount = 0, rdCount = 0;
  logic [6:0] lastWrAddr;
  logic [31:0] lastWrData;
  logic oeInWrite = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  dword_reg_bridge i_dword_reg_bridge (
    .clk(clk), .rstN(rstN), .busCsN(busCsN), .busRdN(busRdN), .busWrN(busWrN),
    .busWideN(busWideN), .busAddr(busAddr), .busDataIn(busDataIn),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdData(regRdData)
  );

  assign regRdData = mem[regAddr];

  always @(posedge clk) begin
    if (regWrEn) begin
      mem[regAddr] <= regWrData;
      wrCount <= wrCount + 1;
      lastWrAddr <= regAddr;
      lastWrData <= regWrData;
    end
    if (regRdEn) rdCount <= rdCount + 1;
    if (busDataOe && !busWrN) oeInWrite <= 1'b1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busDataIn = d; busCsN = 1'b0; busWrN = 1'b0;
    repeat (6) @(negedge clk);
    busWrN = 1'b1;
    repeat (3) @(negedge clk);
    busCsN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic busRead(logic [6:0] a, output logic [31:0] d, output logic oe);
    @(negedge clk);
    busAddr = a; busCsN = 1'b0; busRdN = 1'b0;
    repeat (6) @(negedge clk);
    d = busDataOut; oe = busDataOe;
    busRdN = 1'b1;
    repeat (2) @(negedge clk);
    busCsN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 wrEn", {31'b0, regWrEn}, 32'd0);
    check("R1 rdEn", {31'b0, regRdEn}, 32'd0);
    check("R1 oe", {31'b0, busDataOe}, 32'd0);
  endtask

  task automatic testWide();
    logic [31:0] d; logic oe; int w0;
    busWideN = 1'b1; repeat (3) @(negedge clk);
    w0 = wrCount;
    busWrite(7'd5, 32'hA1B2C3D4);
    check("R2 count", wrCount - w0, 32'd1);
    check("R2 data", mem[5], 32'hA1B2C3D4);
    check("R7 no oe in write", {31'b0, oeInWrite}, 32'd0);
    busRead(7'd5, d, oe);
    check("R4 data", d, 32'hA1B2C3D4);
    check("R7 oe in read", {31'b0, oe}, 32'd1);
    check("R7 oe idle", {31'b0, busDataOe}, 32'd0);
  endtask

  task automatic testSplitWrite();
    int w0;
    busWideN = 1'b0; repeat (3) @(negedge clk);
    w0 = wrCount;
    busWrite(7'd9, 32'hFFFF1234);
    check("R3 low no write", wrCount - w0, 32'd0);
    busWrite(7'd9, 32'hEEEE5678);
    check("R3 one write", wrCount - w0, 32'd1);
    check("R3 data", mem[9], 32'h56781234);
  endtask

  task automatic testSplitRead();
    logic [31:0] d; logic oe; int r0;
    mem[12] = 32'hCAFEBEEF;
    r0 = rdCount;
    busRead(7'd12, d, oe);
    check("R5 low", d, 32'h0000BEEF);
    mem[12] = 32'h11112222;
    busRead(7'd12, d, oe);
    check("R5 high snapshot", d, 32'h0000CAFE);
    check("R5 one inner read", rdCount - r0, 32'd1);
  endtask

  task automatic testAddrChange();
    int w0;
    mem[20] = 32'h0; mem[21] = 32'h0;
    w0 = wrCount;
    busWrite(7'd20, 32'h0000AAAA);
    busWrite(7'd21, 32'h0000BBBB);
    check("R6 no write", wrCount - w0, 32'd0);
    busWrite(7'd21, 32'h0000CCCC);
    check("R6 addr", {25'b0, lastWrAddr}, 32'd21);
    check("R6 data", mem[21], 32'hCCCCBBBB);
    check("R6 old untouched", mem[20], 32'h0);
  endtask

  task automatic testDirChange();
    logic [31:0] d; logic oe; int w0;
    mem[30] = 32'h0;
    w0 = wrCount;
    busWrite(7'd30, 32'h00001111);
    busRead(7'd30, d, oe);
    busWrite(7'd30, 32'h00002222);
    check("R9 new pair no write", wrCount - w0, 32'd0);
    busWrite(7'd30, 32'h00003333);
    check("R9 data", mem[30], 32'h33332222);
  endtask

  task automatic testResetMid();
    int w0;
    mem[40] = 32'h0;
    w0 = wrCount;
    busWrite(7'd40, 32'h00004444);
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    repeat (2) @(negedge clk);
    busWrite(7'd40, 32'h00005555);
    check("R8 no write", wrCount - w0, 32'd0);
    busWrite(7'd40, 32'h00006666);
    check("R8 data", mem[40], 32'h66665555);
  endtask

  task automatic testAddrEnds();
    logic [31:0] d; logic oe;
    busWideN = 1'b1; repeat (3) @(negedge clk);
    busWrite(7'd127, 32'h7F7F7F7F);
    busWrite(7'd0, 32'h01010101);
    check("R10 top addr", {25'b0, lastWrAddr}, 32'd0);
    busRead(7'd127, d, oe);
    check("R10 top", d, 32'h7F7F7F7F);
    busRead(7'd0, d, oe);
    check("R10 bottom", d, 32'h01010101);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testWide();
    testSplitWrite();
    testSplitRead();
    testAddrChange();
    testDirChange();
    testResetMid();
    testAddrEnds();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule